// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit general-purpose timer behind a small register port. A counter advances once per prescaled tick, where the tick source is either the system clock or the system clock divided by a fixed factor, and the tick is further divided by an 8-bit prescale value plus one. When the counter reaches the value held in the reference register, it restarts from zero and latches a reference event flag. That flag, gated by an interrupt enable bit, drives a single level-sensitive interrupt output.

Software configures the timer through four registers: mode, reference, counter and event. The counter can be loaded at any time. The event flag is cleared by writing a one to its bit. A run bit in the mode register holds the timer stopped while it is low. Clearing the run bit by a write returns the counter, reference and event state to their reset values. Any write to the mode or reference register restarts the prescaler, so new settings take effect from a clean tick boundary.

Top module: `ref_cmp_timer`

## Requirements
- R1: After reset the mode register (offset 0) reads 0x0000, the reference register (offset 1) reads 0xFFFF, the counter (offset 2) reads 0, the event register (offset 3) reads 0 and `irq` is low.
- R2: Mode bits 15:8 hold a prescale value P. The counter advances once per P+1 source ticks.
- R3: Mode bits 2:1 pick the source. Value 1 ticks on every clock, and value 2 ticks once every 16 clocks. Values 0 and 3 produce no counting.
- R4: While mode bit 0 (run) is 0, the counter holds its value. A mode write that takes bit 0 from 1 to 0 sets the counter to 0, the reference to 0xFFFF and the event flag to 0.
- R5: On a tick where the counter plus one equals the reference, the counter becomes 0 and the event flag (event register bit 1) is set. The period is therefore the reference value in ticks.
- R6: A counter write loads the written value. The write takes priority over a tick in the same cycle, and in that cycle no event is raised.
- R7: A write to the mode or reference register restarts the prescale and divide-by-16 counts. The next tick then comes a full P+1 source ticks later.
- R8: `irq` is high exactly when mode bit 4 (interrupt enable) and the event flag are both 1. It follows a register write from the next clock cycle.
- R9: Writing the event register with bit 1 set clears the flag, and writing 0 to bit 1 leaves the flag unchanged. If a reference hit falls in the same cycle as the clear, the flag stays set.
- R10: Offsets 4 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of operations can land on the same clock edge. The first pair is a write-one-to-clear of the event flag and a reference hit. The second pair is a counter load and a counting tick. The bench times each write from the known tick schedule, so that its edge matches the cycle of the next hit. It then judges from the event register and the counter value whether the hit kept the flag set and whether the loaded value won over the increment.

// File: rtl/ref_cmp_timer.sv
module ref_cmp_timer #(
  parameter int CNT_W    = 16,
  parameter int PS_W     = 8,
  parameter int ADDR_W   = 3,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int PS_LSB = 8;

  logic [CNT_W-1:0] mode_q, ref_q, cnt_q;
  logic             flag_q;
  logic [PS_W-1:0]  pre_q;
  logic [DIV_W-1:0] div_q;

  wire sel_mode = wr_en && addr == ADDR_W'(0);
  wire sel_ref  = wr_en && addr == ADDR_W'(1);
  wire sel_cnt  = wr_en && addr == ADDR_W'(2);
  wire sel_evt  = wr_en && addr == ADDR_W'(3);

  wire [1:0]      src      = mode_q[2:1];
  wire [PS_W-1:0] prescale = mode_q[PS_LSB +: PS_W];
  wire run      = mode_q[0] && (src == 2'd1 || src == 2'd2);
  wire slow_hit = (div_q == DIV_W'(SLOW_DIV - 1));
  wire src_tick = (src == 2'd1) || slow_hit;
  wire tick     = run && src_tick && (pre_q == prescale);
  wire [CNT_W-1:0] cnt_inc = cnt_q + 1'b1;
  wire hit      = tick && (cnt_inc == ref_q);
  wire drop     = sel_mode && mode_q[0] && !wdata[0];
  wire restart  = sel_mode || sel_ref;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      div_q <= slow_hit ? '0 : div_q + 1'b1;
      if (src_tick)
        pre_q <= (pre_q == prescale) ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '1;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (sel_mode) mode_q <= wdata;
      if (drop) begin
        ref_q  <= '1;
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (sel_ref) ref_q <= wdata;
        if (sel_cnt)   cnt_q <= wdata;
        else if (tick) cnt_q <= hit ? '0 : cnt_inc;
        if (hit && !sel_cnt)          flag_q <= 1'b1;
        else if (sel_evt && wdata[1]) flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rdata = mode_q;
      ADDR_W'(1): rdata = ref_q;
      ADDR_W'(2): rdata = cnt_q;
      ADDR_W'(3): rdata = {{(CNT_W-2){1'b0}}, flag_q, 1'b0};
      default:    rdata = '0;
    endcase
  end

  assign irq = mode_q[4] && flag_q;
endmodule

// File: rtl/ref_cmp_timer_chk.sv
module ref_cmp_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  mode_q,
  input logic [CNT_W-1:0]  ref_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              flag_q
);
  a_r4_drop_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && mode_q[0] && !wdata[0])
      |=> (cnt_q == '0 && ref_q == '1 && !flag_q));

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[0] && !wr_en) |=> $stable(cnt_q));

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(2)) |=> cnt_q == $past(wdata));

  a_r5_wrap_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> cnt_q == '0);

  a_r9_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(wr_en && addr == ADDR_W'(3) && wdata[1]) ||
                       $past(wr_en && addr == ADDR_W'(0) && mode_q[0] && !wdata[0])));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode_q[4] && flag_q));

  a_r10_undecoded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= ADDR_W'(4)) |=> ($stable(mode_q) && $stable(ref_q)));
endmodule

bind ref_cmp_timer ref_cmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .mode_q(mode_q), .ref_q(ref_q), .cnt_q(cnt_q), .flag_q(flag_q)
);

// File: tb/ref_cmp_timer_bench.sv
module ref_cmp_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  ref_cmp_timer u_ref_cmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(3'd0, v); check("R1 mode", v, 16'h0000);
    rd(3'd1, v); check("R1 ref", v, 16'hFFFF);
    rd(3'd2, v); check("R1 count", v, 16'h0000);
    rd(3'd3, v); check("R1 event", v, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_prescale();
    logic [15:0] v;
    do_reset();
    wr(3'd1, 16'd4);
    wr(3'd0, 16'h0203);
    wait_cyc(11);
    rd(3'd3, v); check("R2 no event before 12 clocks", v, 16'h0000);
    rd(3'd2, v); check("R2 count after 11 clocks", v, 16'd3);
    wait_cyc(1);
    rd(3'd3, v); check("R5 event at 12 clocks", v, 16'h0002);
    rd(3'd2, v); check("R5 wrap to zero", v, 16'd0);
    check("R8 irq low while disabled", {15'b0, irq}, 16'h0000);
    wr(3'd0, 16'h0213);
    check("R8 irq high once enabled", {15'b0, irq}, 16'h0001);
  endtask

  task automatic t_source();
    logic [15:0] v;
    do_reset();
    wr(3'd1, 16'd2);
    wr(3'd0, 16'h0005);
    wait_cyc(31);
    rd(3'd3, v); check("R3 slow source no event at 31", v, 16'h0000);
    wait_cyc(1);
    rd(3'd3, v); check("R3 slow source event at 32", v, 16'h0002);
    do_reset();
    wr(3'd0, 16'h0001);
    wait_cyc(40);
    rd(3'd2, v); check("R3 source 0 idle", v, 16'd0);
    wr(3'd0, 16'h0007);
    wait_cyc(40);
    rd(3'd2, v); check("R3 source 3 idle", v, 16'd0);
  endtask

  task automatic t_disable();
    logic [15:0] v;
    do_reset();
    wr(3'd1, 16'd50);
    wr(3'd0, 16'h0003);
    wait_cyc(20);
    rd(3'd2, v); check("R5 count while running", v, 16'd20);
    wr(3'd0, 16'h0002);
    rd(3'd2, v); check("R4 drop clears count", v, 16'd0);
    rd(3'd1, v); check("R4 drop restores ref", v, 16'hFFFF);
    wait_cyc(10);
    rd(3'd2, v); check("R4 held while stopped", v, 16'd0);
  endtask

  task automatic t_load();
    logic [15:0] v;
    do_reset();
    wr(3'd2, 16'h1234);
    rd(3'd2, v); check("R6 load while stopped", v, 16'h1234);
    wr(3'd1, 16'd10);
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'd9);
    rd(3'd2, v); check("R6 load wins over tick", v, 16'd9);
    rd(3'd3, v); check("R6 no event on load cycle", v, 16'h0000);
    wait_cyc(1);
    rd(3'd3, v); check("R5 event after loaded value", v, 16'h0002);
    rd(3'd2, v); check("R5 wrap after load", v, 16'd0);
  endtask

  task automatic t_restart();
    logic [15:0] v;
    do_reset();
    wr(3'd1, 16'd100);
    wr(3'd0, 16'h0303);
    wait_cyc(2);
    wr(3'd1, 16'd100);
    wait_cyc(3);
    rd(3'd2, v); check("R7 prescaler restarted", v, 16'd0);
    wait_cyc(1);
    rd(3'd2, v); check("R7 tick after full prescale", v, 16'd1);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    do_reset();
    wr(3'd1, 16'd3);
    wr(3'd0, 16'h0013);
    wait_cyc(3);
    rd(3'd3, v); check("R5 event at third tick", v, 16'h0002);
    check("R8 irq follows flag", {15'b0, irq}, 16'h0001);
    wr(3'd3, 16'h0001);
    rd(3'd3, v); check("R9 bit1 zero keeps flag", v, 16'h0002);
    wait_cyc(1);
    wr(3'd3, 16'h0002);
    rd(3'd3, v); check("R9 hit beats clear", v, 16'h0002);
    wr(3'd3, 16'h0002);
    rd(3'd3, v); check("R9 clear", v, 16'h0000);
    check("R8 irq drops after clear", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_undecoded();
    logic [15:0] v;
    do_reset();
    wr(3'd5, 16'hABCD);
    rd(3'd5, v); check("R10 undecoded reads zero", v, 16'h0000);
    rd(3'd0, v); check("R10 mode untouched", v, 16'h0000);
    rd(3'd1, v); check("R10 ref untouched", v, 16'hFFFF);
    rd(3'd2, v); check("R10 count untouched", v, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_prescale();
    t_source();
    t_disable();
    t_load();
    t_restart();
    t_collide();
    t_undecoded();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule